// File: doc/BRIEF.md
# Dual-Port Mailbox Interrupt Logic

This block generates the two doorbell interrupts of a two-port shared word memory. The two highest word addresses serve as mailboxes, one for each port. When one port writes the mailbox that belongs to its peer, the peer's interrupt line goes low. The peer acknowledges the interrupt by accessing its own mailbox with the chip enable and the output enable both active. Both mailbox words remain ordinary storage. The message a port writes there stays in the memory array, which lies outside this block. Only the side effect on the flags is modelled here.

Port A owns the mailbox at the top address minus one (0x7FFE with the default 15-bit address). Port B owns the mailbox at the top address (0x7FFF). Each port also supplies an active-low busy qualifier. While that qualifier is low, every set or clear that the port's own access would cause is suppressed. There are no control registers. The flags are changed only by accesses to the two fixed addresses.

Top module: `mbx_irq`

## Requirements
- R1: While rstN is low, and in the first cycle after it is released, aIrqN and bIrqN are both 1 (deasserted).
- R2: A port B write (bEnN=0, bWeN=0, bBusyN=1) to address 2^ADDR_W-2 drives aIrqN to 0 at the next rising clock edge. It stays 0 until it is cleared.
- R3: A port A write (aEnN=0, aWeN=0, aBusyN=1) to address 2^ADDR_W-1 drives bIrqN to 0 at the next rising clock edge.
- R4: A port A access to address 2^ADDR_W-2 with aEnN=0, aOeN=0 and aBusyN=1 returns aIrqN to 1 at the next edge, whatever the level of aWeN.
- R5: A port B access to address 2^ADDR_W-1 with bEnN=0, bOeN=0 and bBusyN=1 returns bIrqN to 1 at the next edge, whatever the level of bWeN.
- R6: A port whose busy input is 0 causes no set and no clear through its own access. The other port's busy input has no effect on that access.
- R7: When a set and a clear of the same flag fall in the same cycle, the flag ends up asserted (0).
- R8: An access with the enable high, to a non-mailbox address, a read of the peer's mailbox, or an own-mailbox access with the output enable high leaves both flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| aEnN | input | 1 | Port A enable, active low |
| aOeN | input | 1 | Port A output enable, active low |
| aWeN | input | 1 | Port A read/write, 0 = write |
| aAddr | input | ADDR_W | Port A word address |
| aBusyN | input | 1 | Port A busy qualifier, 0 blocks its side effects |
| bEnN | input | 1 | Port B enable, active low |
| bOeN | input | 1 | Port B output enable, active low |
| bWeN | input | 1 | Port B read/write, 0 = write |
| bAddr | input | ADDR_W | Port B word address |
| bBusyN | input | 1 | Port B busy qualifier, 0 blocks its side effects |
| aIrqN | output | 1 | Port A interrupt, active low |
| bIrqN | output | 1 | Port B interrupt, active low |

## Verification
The bench builds the block with its default ADDR_W of 15, so the mailboxes sit at 0x7FFE and 0x7FFF. With these values the neighbouring address 0x7FFD and each port's access to the other mailbox can be driven directly. An address that differs from a mailbox only in its lowest bit therefore shows whether each port decodes its own slot. The behavioural model checks both flags after every clock, including the cycles where a set and a clear collide and where only one of the two busy inputs is low.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int NUM_PORTS = 2;
  localparam int PORT_A = 0;
  localparam int PORT_B = 1;

  typedef struct packed {
    logic [NUM_PORTS-1:0] set;
    logic [NUM_PORTS-1:0] clr;
  } mbxStrobe_t;
endpackage

// File: rtl/mbx_decode.sv
module mbx_decode
  import mbx_pkg::*;
#(
  parameter int ADDR_W = 15
) (
  input  logic [NUM_PORTS-1:0]             enN,
  input  logic [NUM_PORTS-1:0]             oeN,
  input  logic [NUM_PORTS-1:0]             weN,
  input  logic [NUM_PORTS-1:0][ADDR_W-1:0] addr,
  input  logic [NUM_PORTS-1:0]             busyN,
  output mbxStrobe_t                       strobe
);
  localparam logic [ADDR_W-1:0] TOP_ADDR = {ADDR_W{1'b1}};

  logic [NUM_PORTS-1:0] active;
  logic [NUM_PORTS-1:0] hitOwn;
  logic [NUM_PORTS-1:0] hitPeer;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    localparam int PEER = NUM_PORTS - 1 - p;
    // port A owns top-1, port B owns top
    localparam logic [ADDR_W-1:0] OWN_BOX  = TOP_ADDR - ADDR_W'(PEER);
    localparam logic [ADDR_W-1:0] PEER_BOX = TOP_ADDR - ADDR_W'(p);

    always_comb begin
      active[p]  = !enN[p] && busyN[p];
      hitOwn[p]  = (addr[p] == OWN_BOX);
      hitPeer[p] = (addr[p] == PEER_BOX);
    end

    always_comb begin
      strobe.clr[p] = active[p] && !oeN[p] && hitOwn[p];
      strobe.set[p] = active[PEER] && !weN[PEER] && hitPeer[PEER];
    end
  end
endmodule

// File: rtl/mbx_flags.sv
module mbx_flags
  import mbx_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  mbxStrobe_t           strobe,
  output logic [NUM_PORTS-1:0] irqN
);
  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_flag
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                irqN[p] <= 1'b1;
      else if (strobe.set[p])   irqN[p] <= 1'b0;
      else if (strobe.clr[p])   irqN[p] <= 1'b1;
    end
  end
endmodule

// File: rtl/mbx_irq.sv
module mbx_irq
  import mbx_pkg::*;
#(
  parameter int ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              aEnN,
  input  logic              aOeN,
  input  logic              aWeN,
  input  logic [ADDR_W-1:0] aAddr,
  input  logic              aBusyN,
  input  logic              bEnN,
  input  logic              bOeN,
  input  logic              bWeN,
  input  logic [ADDR_W-1:0] bAddr,
  input  logic              bBusyN,
  output logic              aIrqN,
  output logic              bIrqN
);
  mbxStrobe_t strobe;
  logic [NUM_PORTS-1:0] irqN;

  mbx_decode #(.ADDR_W(ADDR_W)) u_decode (
    .enN   ({bEnN, aEnN}),
    .oeN   ({bOeN, aOeN}),
    .weN   ({bWeN, aWeN}),
    .addr  ({bAddr, aAddr}),
    .busyN ({bBusyN, aBusyN}),
    .strobe(strobe)
  );

  mbx_flags u_flags (
    .clk   (clk),
    .rstN  (rstN),
    .strobe(strobe),
    .irqN  (irqN)
  );

  assign aIrqN = irqN[PORT_A];
  assign bIrqN = irqN[PORT_B];
endmodule

// File: rtl/mbx_irq_chk.sv
module mbx_irq_chk #(
  parameter int ADDR_W = 15
) (
  input logic              clk,
  input logic              rstN,
  input logic              aEnN,
  input logic              aOeN,
  input logic              aWeN,
  input logic [ADDR_W-1:0] aAddr,
  input logic              aBusyN,
  input logic              bEnN,
  input logic              bOeN,
  input logic              bWeN,
  input logic [ADDR_W-1:0] bAddr,
  input logic              bBusyN,
  input logic              aIrqN,
  input logic              bIrqN
);
  localparam logic [ADDR_W-1:0] BOX_B = {ADDR_W{1'b1}};
  localparam logic [ADDR_W-1:0] BOX_A = BOX_B - 1'b1;

  logic setA, setB, clrA, clrB;
  always_comb begin
    setA = !bEnN && !bWeN && bBusyN && (bAddr == BOX_A);
    setB = !aEnN && !aWeN && aBusyN && (aAddr == BOX_B);
    clrA = !aEnN && !aOeN && aBusyN && (aAddr == BOX_A);
    clrB = !bEnN && !bOeN && bBusyN && (bAddr == BOX_B);
  end

  a_r2_set_a: assert property (@(posedge clk) disable iff (!rstN)
    setA |=> !aIrqN);
  a_r3_set_b: assert property (@(posedge clk) disable iff (!rstN)
    setB |=> !bIrqN);
  a_r4_clear_a: assert property (@(posedge clk) disable iff (!rstN)
    (clrA && !setA) |=> aIrqN);
  a_r5_clear_b: assert property (@(posedge clk) disable iff (!rstN)
    (clrB && !setB) |=> bIrqN);
  a_r6_busy_block: assert property (@(posedge clk) disable iff (!rstN)
    (!aBusyN && !bBusyN) |=> ($stable(aIrqN) && $stable(bIrqN)));
  a_r7_set_wins: assert property (@(posedge clk) disable iff (!rstN)
    (setA && clrA) |=> !aIrqN);
  a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    (aEnN && bEnN) |=> ($stable(aIrqN) && $stable(bIrqN)));
endmodule

bind mbx_irq mbx_irq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN),
  .aEnN(aEnN), .aOeN(aOeN), .aWeN(aWeN), .aAddr(aAddr), .aBusyN(aBusyN),
  .bEnN(bEnN), .bOeN(bOeN), .bWeN(bWeN), .bAddr(bAddr), .bBusyN(bBusyN),
  .aIrqN(aIrqN), .bIrqN(bIrqN)
);

// File: tb/mbx_irq_tb.sv
module mbx_irq_tb;
  localparam int ADDR_W = 15;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic aEnN = 1, aOeN = 1, aWeN = 1, aBusyN = 1;
  logic bEnN = 1, bOeN = 1, bWeN = 1, bBusyN = 1;
  logic [ADDR_W-1:0] aAddr = '0, bAddr = '0;
  logic aIrqN, bIrqN;

  int checks = 0;
  int errors = 0;
  int expA = 1;
  int expB = 1;
  bit done = 0;

  always #4 clk = ~clk;

  mbx_irq #(.ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rstN(rstN),
    .aEnN(aEnN), .aOeN(aOeN), .aWeN(aWeN), .aAddr(aAddr), .aBusyN(aBusyN),
    .bEnN(bEnN), .bOeN(bOeN), .bWeN(bWeN), .bAddr(bAddr), .bBusyN(bBusyN),
    .aIrqN(aIrqN), .bIrqN(bIrqN)
  );

  task automatic compare(input string tag);
    checks++;
    if (aIrqN !== expA[0] || bIrqN !== expB[0]) begin
      errors++;
      $display("FAIL %s: aIrqN=%b bIrqN=%b expected %0d %0d", tag, aIrqN, bIrqN, expA, expB);
    end
  endtask

  task automatic idle();
    aEnN = 1; aOeN = 1; aWeN = 1; aBusyN = 1; aAddr = 0;
    bEnN = 1; bOeN = 1; bWeN = 1; bBusyN = 1; bAddr = 0;
  endtask

  // Reference model: evaluate the current access pair, advance one clock, compare.
  task automatic step(input string tag);
    int mbA = 32766;
    int mbB = 32767;
    bit sA = !bEnN && !bWeN && bBusyN && (int'(bAddr) == mbA);
    bit sB = !aEnN && !aWeN && aBusyN && (int'(aAddr) == mbB);
    bit cA = !aEnN && !aOeN && aBusyN && (int'(aAddr) == mbA);
    bit cB = !bEnN && !bOeN && bBusyN && (int'(bAddr) == mbB);
    if (sA) expA = 0; else if (cA) expA = 1;
    if (sB) expB = 0; else if (cB) expB = 1;
    @(negedge clk);
    compare(tag);
    idle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    expA = 1; expB = 1;
    compare("R1 during reset");
    rstN = 1;
    step("R1 after release");
    // R2: B writes A's mailbox
    bEnN = 0; bWeN = 0; bAddr = 15'h7FFE; step("R2 set aIrqN");
    step("R2 hold");
    // R8: A own-mailbox access with oe high does not clear
    aEnN = 0; aAddr = 15'h7FFE; step("R8 oe high no clear");
    // R4: clear with a write level on aWeN
    aEnN = 0; aOeN = 0; aWeN = 0; aAddr = 15'h7FFE; step("R4 clear with write level");
    // R3
    aEnN = 0; aWeN = 0; aAddr = 15'h7FFF; step("R3 set bIrqN");
    // R8: B reads A's mailbox, A writes non-mailbox
    bEnN = 0; bOeN = 0; bAddr = 15'h7FFE; aEnN = 0; aWeN = 0; aAddr = 15'h7FFD;
    step("R8 peer read and neighbour write");
    // R5
    bEnN = 0; bOeN = 0; bAddr = 15'h7FFF; step("R5 clear bIrqN");
    // R6: A busy blocks its set
    aEnN = 0; aWeN = 0; aAddr = 15'h7FFF; aBusyN = 0; step("R6 busy blocks set");
    // R6: A busy does not block B's access
    bEnN = 0; bWeN = 0; bAddr = 15'h7FFE; aBusyN = 0; step("R6 other busy ignored");
    // R6: A busy blocks its clear
    aEnN = 0; aOeN = 0; aAddr = 15'h7FFE; aBusyN = 0; step("R6 busy blocks clear");
    // R7: set and clear of aIrqN together
    aEnN = 0; aOeN = 0; aAddr = 15'h7FFE; bEnN = 0; bWeN = 0; bAddr = 15'h7FFE;
    step("R7 set wins on A");
    // R7: set and clear of bIrqN together (from deasserted state)
    aEnN = 0; aWeN = 0; aAddr = 15'h7FFF; bEnN = 0; bOeN = 0; bAddr = 15'h7FFF;
    step("R7 set wins on B");
    // R8: enable high
    aEnN = 1; aOeN = 0; aAddr = 15'h7FFE; bEnN = 1; bOeN = 0; bAddr = 15'h7FFF;
    step("R8 enable high");
    // R8: A writes its own mailbox, oe high
    aEnN = 0; aWeN = 0; aAddr = 15'h7FFE; step("R8 own write no effect");
    // R8: B writes an address one below the mailbox
    bEnN = 0; bWeN = 0; bAddr = 15'h7FFD; step("R8 neighbour no set");
    // clear both, then reset with flags asserted
    aEnN = 0; aOeN = 0; aAddr = 15'h7FFE; bEnN = 0; bOeN = 0; bAddr = 15'h7FFF;
    step("R4 R5 clear both");
    aEnN = 0; aWeN = 0; aAddr = 15'h7FFF; bEnN = 0; bWeN = 0; bAddr = 15'h7FFE;
    step("R2 R3 set both");
    rstN = 0; #1; expA = 1; expB = 1;
    compare("R1 async reset");
    @(negedge clk); rstN = 1;
    step("R1 after second release");
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired: actual hung expected finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule